// File: doc/BRIEF.md
# Condition Code Test and Loop Unit

This block evaluates one of sixteen flag conditions against the negative, zero, overflow and carry flags. The result feeds one of three consumers, chosen by an operation select. In branch mode it drives a taken bit. In set mode it drives a byte that is all ones or all zeros. In loop mode it performs a counted decrement-and-branch step on the low half of a 32-bit counter.

The loop step works the opposite way from a normal branch. When the condition holds, the loop falls through and the counter is not touched. When it does not hold, the low word is decremented, and the loop branches back unless the new low word is 0xFFFF. A counter loaded with N therefore gives N+1 passes.

All outputs are registered. They are updated one cycle after a valid strobe and hold their values between strobes.

Top module: `ccLoopUnit`

## Requirements
- R1: Condition encoding: 0 always true, 1 always false, 2 higher (C=0 and Z=0), 3 lower-or-same (C=1 or Z=1), 4 C=0, 5 C=1, 6 Z=0, 7 Z=1, 8 V=0, 9 V=1, 10 N=0, 11 N=1, 12 N==V, 13 N!=V, 14 Z=0 and N==V, 15 Z=1 or N!=V.
- R2: Operation select encoding is 0 for branch, 1 for set and 2 for loop. Value 3 behaves as branch.
- R3: In branch mode, `taken` equals the condition result. Code 1 is therefore never taken.
- R4: In set mode, `setByte` is 0xFF when the condition holds and 0x00 otherwise.
- R5: In loop mode with the condition true, `cntOut` equals `cntIn` and `loopBranch` is 0.
- R6: In loop mode with the condition false, bits 15:0 of `cntOut` are the low word of `cntIn` minus one, wrapping modulo 65536. `loopBranch` is 1 unless that new low word is 0xFFFF.
- R7: In loop mode, bits 31:16 of `cntOut` always equal bits 31:16 of `cntIn`.
- R8: With condition 1 and a counter whose low word starts at 7, feeding the counter back gives eight decrements and seven branches, and the low word ends at 0xFFFF.
- R9: Outputs update on the clock edge after `valid` is high. Without `valid` they hold. After reset they are all zero.
- R10: An operation updates only its own outputs. The outputs of the other operations hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Operation strobe |
| opSel | input | 2 | 0 branch, 1 set, 2 loop |
| cond | input | 4 | Condition code |
| flagN | input | 1 | Negative flag |
| flagZ | input | 1 | Zero flag |
| flagV | input | 1 | Overflow flag |
| flagC | input | 1 | Carry flag |
| cntIn | input | 32 | Counter value |
| taken | output | 1 | Branch taken |
| setByte | output | 8 | Set-operation byte |
| cntOut | output | 32 | Updated counter |
| loopBranch | output | 1 | Loop branches back |

## Verification
The condition result passes through only one register stage. A wrong decode or a wrong mode strobe therefore shows up on the wrong output on the first clock after the strobe. The bench drives every condition against all sixteen flag combinations in every mode and compares each output to a behavioural model on every cycle. A decrement that touches the high word, or an exit tested at zero instead of at 0xFFFF, shows up within one loop step. The chained eight-pass run exposes an off-by-one in the loop count.

// File: rtl/ccLoopPkg.sv
package ccLoopPkg;
  localparam int CNT_W = 32;
  localparam int LOW_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_BRANCH = 2'd0,
    OP_SET    = 2'd1,
    OP_LOOP   = 2'd2,
    OP_RSVD   = 2'd3
  } opSelT;

  typedef struct packed {
    logic loadBranch;
    logic loadSet;
    logic loadLoop;
    logic condTrue;
  } ctlStrobeT;
endpackage

// File: rtl/ccLoopCtrl.sv
module ccLoopCtrl
  import ccLoopPkg::*;
(
  input  logic       valid,
  input  logic [1:0] opSel,
  input  logic [3:0] cond,
  input  logic       flagN,
  input  logic       flagZ,
  input  logic       flagV,
  input  logic       flagC,
  output ctlStrobeT  strobe
);
  logic condHit;
  logic nXorV;

  assign nXorV = flagN ^ flagV;

  always_comb begin
    unique case (cond)
      4'd0:  condHit = 1'b1;
      4'd1:  condHit = 1'b0;
      4'd2:  condHit = !flagC && !flagZ;
      4'd3:  condHit = flagC || flagZ;
      4'd4:  condHit = !flagC;
      4'd5:  condHit = flagC;
      4'd6:  condHit = !flagZ;
      4'd7:  condHit = flagZ;
      4'd8:  condHit = !flagV;
      4'd9:  condHit = flagV;
      4'd10: condHit = !flagN;
      4'd11: condHit = flagN;
      4'd12: condHit = !nXorV;
      4'd13: condHit = nXorV;
      4'd14: condHit = !flagZ && !nXorV;
      default: condHit = flagZ || nXorV;
    endcase
  end

  always_comb begin
    strobe = '0;
    strobe.condTrue = condHit;
    if (valid) begin
      unique case (opSelT'(opSel))
        OP_SET:  strobe.loadSet = 1'b1;
        OP_LOOP: strobe.loadLoop = 1'b1;
        default: strobe.loadBranch = 1'b1;
      endcase
    end
  end

  always_comb begin
    a_r2_one_strobe: assert ($onehot0({strobe.loadBranch, strobe.loadSet, strobe.loadLoop}));
    a_r9_no_strobe_idle: assert (valid || !(strobe.loadBranch || strobe.loadSet || strobe.loadLoop));
  end
endmodule

// File: rtl/ccLoopDatapath.sv
module ccLoopDatapath
  import ccLoopPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         strobe,
  input  logic [CNT_W-1:0]  cntIn,
  output logic              taken,
  output logic [BYTE_W-1:0] setByte,
  output logic [CNT_W-1:0]  cntOut,
  output logic              loopBranch
);
  localparam logic [LOW_W-1:0] EXIT_VAL = '1;

  logic [LOW_W-1:0] lowDec;
  logic [CNT_W-1:0] cntNext;
  logic             branchNext;

  assign lowDec = cntIn[LOW_W-1:0] - LOW_W'(1);

  always_comb begin
    if (strobe.condTrue) begin
      cntNext    = cntIn;
      branchNext = 1'b0;
    end else begin
      cntNext    = {cntIn[CNT_W-1:LOW_W], lowDec};
      branchNext = (lowDec != EXIT_VAL);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      taken      <= 1'b0;
      setByte    <= '0;
      cntOut     <= '0;
      loopBranch <= 1'b0;
    end else begin
      if (strobe.loadBranch) taken <= strobe.condTrue;
      if (strobe.loadSet) setByte <= {BYTE_W{strobe.condTrue}};
      if (strobe.loadLoop) begin
        cntOut     <= cntNext;
        loopBranch <= branchNext;
      end
    end
  end

  a_r7_high_kept: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadLoop |=> cntOut[CNT_W-1:LOW_W] == $past(cntIn[CNT_W-1:LOW_W]));
  a_r5_true_no_change: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadLoop && strobe.condTrue) |=> (cntOut == $past(cntIn)) && !loopBranch);
  a_r6_exit_no_branch: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadLoop && !strobe.condTrue && cntIn[LOW_W-1:0] == '0) |=> !loopBranch);
  a_r4_byte_form: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadSet |=> (setByte == '0 || setByte == '1));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadLoop |=> $stable(cntOut) && $stable(loopBranch));
endmodule

// File: rtl/ccLoopUnit.sv
module ccLoopUnit
  import ccLoopPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        valid,
  input  logic [1:0]  opSel,
  input  logic [3:0]  cond,
  input  logic        flagN,
  input  logic        flagZ,
  input  logic        flagV,
  input  logic        flagC,
  input  logic [31:0] cntIn,
  output logic        taken,
  output logic [7:0]  setByte,
  output logic [31:0] cntOut,
  output logic        loopBranch
);
  ctlStrobeT strobe;

  ccLoopCtrl u_ctrl (
    .valid(valid), .opSel(opSel), .cond(cond),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC),
    .strobe(strobe)
  );

  ccLoopDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cntIn(cntIn),
    .taken(taken), .setByte(setByte), .cntOut(cntOut), .loopBranch(loopBranch)
  );

  a_r3_never_false: assert property (@(posedge clk) disable iff (!rstN)
    (valid && (opSel == 2'd0 || opSel == 2'd3) && cond == 4'd1) |=> !taken);
endmodule

// File: tb/ccLoopUnit_bench.sv
module ccLoopUnit_bench;
  logic clk = 0, rstN = 0, valid = 0;
  logic [1:0] opSel = 0;
  logic [3:0] cond = 0;
  logic flagN = 0, flagZ = 0, flagV = 0, flagC = 0;
  logic [31:0] cntIn = 0;
  logic taken, loopBranch;
  logic [7:0] setByte;
  logic [31:0] cntOut;

  int nTests = 0, nFail = 0;
  logic mTaken = 0, mBr = 0;
  logic [7:0] mByte = 0;
  logic [31:0] mCnt = 0;

  always #10 clk = ~clk;

  ccLoopUnit u_ccLoopUnit (.*);

  function automatic bit refCond(input int c, input bit n, z, v, cy);
    case (c)
      0: return 1; 1: return 0;
      2: return (cy == 0) && (z == 0); 3: return cy || z;
      4: return !cy; 5: return cy; 6: return !z; 7: return z;
      8: return !v; 9: return v; 10: return !n; 11: return n;
      12: return n == v; 13: return n != v;
      14: return (z == 0) && (n == v);
      default: return z || (n != v);
    endcase
  endfunction

  task automatic check(input string tag);
    nTests++;
    if (taken !== mTaken || setByte !== mByte || cntOut !== mCnt || loopBranch !== mBr) begin
      nFail++;
      $display("FAIL %s: got t=%b b=%h c=%h l=%b exp t=%b b=%h c=%h l=%b", tag,
               taken, setByte, cntOut, loopBranch, mTaken, mByte, mCnt, mBr);
    end
  endtask

  task automatic step(input bit v, input int op, input int c, input bit n, z, vf, cy,
                      input logic [31:0] cnt, input string tag);
    bit h;
    int lo;
    valid = v; opSel = 2'(op); cond = 4'(c);
    flagN = n; flagZ = z; flagV = vf; flagC = cy; cntIn = cnt;
    @(posedge clk);
    h = refCond(c, n, z, vf, cy);
    if (v) begin
      if (op == 1) mByte = h ? 8'hFF : 8'h00;
      else if (op == 2) begin
        if (h) begin mCnt = cnt; mBr = 0; end
        else begin
          lo = (int'(cnt[15:0]) + 65535) % 65536;
          mCnt = {cnt[31:16], 16'(lo)};
          mBr = (lo != 65535);
        end
      end else mTaken = h;
    end
    #5 check(tag);
  endtask

  initial begin
    #4_000_000;
    nFail++;
    $display("FAIL watchdog: got hung expected done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [31:0] c;
    repeat (3) @(posedge clk);
    #5 check("R9 reset");
    rstN = 1;
    // R1 R3 R4 R5 R6 R7 R10: every condition, every flag mix, each mode
    for (int op = 0; op < 4; op++)
      for (int cc = 0; cc < 16; cc++)
        for (int f = 0; f < 16; f++)
          step(1, op, cc, f[3], f[2], f[1], f[0], {16'hA5C3, 16'(f * 3)},
               op == 2 ? "R6 R7 loop" : (op == 1 ? "R4 set" : "R1 R3 branch"));
    // R9: hold without valid
    step(0, 2, 1, 0, 0, 0, 0, 32'h1234_0005, "R9 hold");
    step(0, 1, 0, 0, 0, 0, 0, 32'h0, "R9 hold set");
    // R6 boundaries: low word 0 exits, 1 branches, high word kept
    step(1, 2, 1, 0, 0, 0, 0, 32'hFFFF_0000, "R6 exit at zero");
    step(1, 2, 1, 0, 0, 0, 0, 32'h8000_0001, "R6 one to zero");
    // R5: true condition leaves counter
    step(1, 2, 0, 0, 0, 0, 0, 32'hDEAD_BEEF, "R5 fall through");
    // R8: eight passes from seven
    c = 32'h0042_0007;
    for (int i = 0; i < 8; i++) begin
      step(1, 2, 1, 0, 0, 0, 0, c, "R8 pass");
      c = cntOut;
    end
    nTests++;
    if (cntOut !== 32'h0042_FFFF || loopBranch !== 0) begin
      nFail++;
      $display("FAIL R8: got %h/%b expected 0042ffff/0", cntOut, loopBranch);
    end
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule